// File: doc/BRIEF.md
# Four-Operation Stack Processor Core

A 32-bit stack machine whose whole instruction set is four primitives: a bitwise NAND of the two top stack entries, a one-bit logical shift right of the top entry, a literal push from the instruction stream, and a conditional store. Every other operation, including compares, addition and branches, is left to software built from these four. The top two stack entries sit in registers (T, the top, and N, the next), and a 16-entry spill buffer holds deeper entries.

A single word-addressed memory port carries instruction fetches, literal reads and data writes, one access per cycle. The read data must arrive combinationally in the same cycle as the address. Each 32-bit instruction word holds sixteen 2-bit slots. After a one-cycle fetch, the core runs one slot per cycle. The program counter acts as a memory location at address `PC_LOC`, so a conditional store aimed at that address with an all-ones flag is the only way to transfer control.

Top module: `stk_min_core`

## Requirements
- R1: While rst_ni is low, mem_we_o is 0 and mem_addr_o equals RESET_PC (default 0). The first access after release reads the instruction word at RESET_PC.
- R2: Slot k occupies bits [2k+1:2k] of an instruction word. Slots run from k=0 upward, one per cycle, after a single fetch cycle. A later slot therefore sees the effects of every earlier slot in the same word.
- R3: Code 00 (NAND) sets T to the bitwise inverse of T AND N and removes one entry from the stack.
- R4: Code 01 (SHR) shifts T right by one bit, fills bit 31 with 0, and leaves the stack depth unchanged.
- R5: Code 10 (LIT) pushes the memory word that follows the instruction word. Several LITs in one word take successive following words in slot order. The next instruction word is fetched from the address just past the last literal consumed.
- R6: Code 11 (CSTORE) takes ( addr n flag -- ). With flag 0 it writes n to addr through the memory port. It always removes three entries from the stack.
- R7: A CSTORE with flag all ones and addr equal to PC_LOC (default 32'hFFFF_FFFF) does not write memory. It loads the PC with n, abandons the remaining slots, and fetches the next instruction word from n.
- R8: A CSTORE with any other flag value, or with an all-ones flag and an address other than PC_LOC, neither writes memory nor jumps. It still removes three entries.
- R9: The stack holds 18 values (T, N and 16 spill entries) without losing any. Deeper pushes overwrite the oldest entry silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Word address for fetch, literal read or store |
| mem_rdata_i | input | 32 | Read data, combinational from mem_addr_o |
| mem_we_o | output | 1 | Write strobe for a store |
| mem_wdata_o | output | 32 | Store data |

## Verification
All of the state lives inside the core, so any fault has to surface as a wrong store address, wrong store data or a misplaced read address. A corrupted T or N, or a stack entry lost from the spill buffer, shows up as wrong data at the next flag-0 store that consumes it. That store can come many slots later, so the programs under test store each result immediately. A wrong literal pointer or slot count moves mem_addr_o at the next fetch, within one instruction word of 17 cycles. A wrong jump decision shows up at once, as a store that should have been skipped or a missing store at the target.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_NAND = 2'b00,
    OP_SHR  = 2'b01,
    OP_LIT  = 2'b10,
    OP_CST  = 2'b11
  } op_e;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } state_e;

  localparam int unsigned OP_W = 2;
endpackage

// File: rtl/stk_slot_sel.sv
module stk_slot_sel
  import stk_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOTS  = DW / OP_W,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic [DW-1:0]     ir_i,
  input  logic [SLOT_W-1:0] slot_i,
  output op_e               op_o
);
  logic [OP_W-1:0] slot_codes [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_codes[g] = ir_i[g*OP_W +: OP_W];
  end

  assign op_o = op_e'(slot_codes[slot_i]);
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_NAND: res_o = ~(t_i & n_i);
      OP_SHR:  res_o = {1'b0, t_i[DW-1:1]};
      default: res_o = t_i;
    endcase
  end
endmodule

// File: rtl/stk_spill.sv
module stk_spill #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop1_i,
  input  logic          pop3_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] s0_o,
  output logic [DW-1:0] s1_o,
  output logic [DW-1:0] s2_o
);
  logic [DW-1:0]    ent_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;

  assign ptr_inc = ptr_q + PTR_W'(1);
  // pointer arithmetic wraps; DEPTH is a power of two
  assign s0_o = ent_q[ptr_q];
  assign s1_o = ent_q[ptr_q - PTR_W'(1)];
  assign s2_o = ent_q[ptr_q - PTR_W'(2)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i) begin
      ent_q[ptr_inc] <= din_i;
      ptr_q          <= ptr_inc;
    end else if (pop1_i) begin
      ptr_q <= ptr_q - PTR_W'(1);
    end else if (pop3_i) begin
      ptr_q <= ptr_q - PTR_W'(3);
    end
  end
endmodule

// File: rtl/stk_min_core.sv
module stk_min_core
  import stk_pkg::*;
#(
  parameter int unsigned       DW       = 32,
  parameter int unsigned       DEPTH    = 16,
  parameter logic [DW-1:0]     RESET_PC = '0,
  parameter logic [DW-1:0]     PC_LOC   = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int unsigned SLOTS  = DW / OP_W;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  state_e            state_q;
  logic [DW-1:0]     pc_q, nxt_q, ir_q, t_q, n_q;
  logic [SLOT_W-1:0] slot_q;

  op_e           op_w;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] s0, s1, s2;
  logic          is_exec, is_lit, is_nand, is_cst;
  logic          flag_zero, flag_ones, jump_w, last_slot;
  logic [DW-1:0] nxt_d;

  stk_slot_sel #(.DW(DW), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .ir_i   (ir_q),
    .slot_i (slot_q),
    .op_o   (op_w)
  );

  stk_alu #(.DW(DW)) u_alu (
    .op_i  (op_w),
    .t_i   (t_q),
    .n_i   (n_q),
    .res_o (alu_res)
  );

  stk_spill #(.DW(DW), .DEPTH(DEPTH)) u_spill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (is_lit),
    .pop1_i (is_nand),
    .pop3_i (is_cst),
    .din_i  (n_q),
    .s0_o   (s0),
    .s1_o   (s1),
    .s2_o   (s2)
  );

  assign is_exec   = (state_q == ST_EXEC);
  assign is_lit    = is_exec && (op_w == OP_LIT);
  assign is_nand   = is_exec && (op_w == OP_NAND);
  assign is_cst    = is_exec && (op_w == OP_CST);
  assign flag_zero = (t_q == '0);
  assign flag_ones = (t_q == '1);
  assign jump_w    = is_cst && flag_ones && (s0 == PC_LOC);
  assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));
  assign nxt_d     = nxt_q + DW'(is_lit);

  always_comb begin
    if (!is_exec)    mem_addr_o = pc_q;
    else if (is_cst) mem_addr_o = s0;
    else             mem_addr_o = nxt_q;
  end

  assign mem_we_o    = is_cst && flag_zero;
  assign mem_wdata_o = n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      nxt_q   <= RESET_PC;
      ir_q    <= '0;
      slot_q  <= '0;
      t_q     <= '0;
      n_q     <= '0;
    end else if (!is_exec) begin
      ir_q    <= mem_rdata_i;
      nxt_q   <= pc_q + DW'(1);
      slot_q  <= '0;
      state_q <= ST_EXEC;
    end else begin
      unique case (op_w)
        OP_LIT: begin
          t_q <= mem_rdata_i;
          n_q <= t_q;
        end
        OP_NAND: begin
          t_q <= alu_res;
          n_q <= s0;
        end
        OP_SHR: t_q <= alu_res;
        OP_CST: begin
          t_q <= s1;
          n_q <= s2;
        end
        default: ;
      endcase
      nxt_q <= nxt_d;
      if (jump_w) begin
        pc_q    <= n_q;
        state_q <= ST_FETCH;
      end else if (last_slot) begin
        pc_q    <= nxt_d;
        state_q <= ST_FETCH;
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/stk_min_core_chk.sv
module stk_min_core_chk #(
  parameter int unsigned   DW     = 32,
  parameter int unsigned   SLOTS  = 16,
  parameter int unsigned   SLOT_W = 4,
  parameter logic [DW-1:0] PC_LOC = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              is_exec,
  input logic [1:0]        op,
  input logic [DW-1:0]     t_q,
  input logic [DW-1:0]     n_q,
  input logic [DW-1:0]     s0,
  input logic [DW-1:0]     pc_q,
  input logic [DW-1:0]     nxt_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic              mem_we_o
);
  logic take;
  assign take = is_exec && (op == 2'b11) && (t_q == '1) && (s0 == PC_LOC);

  AST_FETCH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_exec |-> !mem_we_o); // R1

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_exec |=> is_exec && slot_q == '0); // R2

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && slot_q != SLOT_W'(SLOTS - 1) && !take) |=>
      (is_exec && slot_q == $past(slot_q) + SLOT_W'(1))); // R2

  AST_NAND_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op == 2'b00) |=> t_q == ~($past(t_q) & $past(n_q))); // R3

  AST_SHR_MSB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op == 2'b01) |=> (t_q[DW-1] == 1'b0 && $stable(n_q))); // R4

  AST_LIT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op == 2'b10) |=> nxt_q == $past(nxt_q) + DW'(1)); // R5

  AST_JUMP_LOADS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> !mem_we_o ##1 (!is_exec && pc_q == $past(n_q))); // R7

  AST_ODD_FLAG_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && op == 2'b11 && t_q != '0) |-> !mem_we_o); // R8
endmodule

bind stk_min_core stk_min_core_chk #(
  .DW(DW), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .PC_LOC(PC_LOC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .is_exec  (is_exec),
  .op       (op_w),
  .t_q      (t_q),
  .n_q      (n_q),
  .s0       (s0),
  .pc_q     (pc_q),
  .nxt_q    (nxt_q),
  .slot_q   (slot_q),
  .mem_we_o (mem_we_o)
);

// File: tb/test_stk_min_core.sv
`timescale 1ns/1ps
module test_stk_min_core;
  localparam int HALT = 200;
  localparam int RUN  = 250;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we;
  logic [31:0] mem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int wp      = 0;
  logic [1:0]  op_q  [$];
  logic [31:0] lit_q [$];

  always #2.5 clk = ~clk;

  stk_min_core i_stk_min_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  function automatic logic [31:0] f_nand(logic [31:0] a, logic [31:0] b);
    return ~(a & b);
  endfunction

  function automatic logic [31:0] f_shr(logic [31:0] a, int k);
    return a >> k;
  endfunction

  function automatic logic [31:0] sent(int i);
    return 32'h5A5A_0000 | 32'(i);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic O(logic [1:0] c);
    op_q.push_back(c);
  endtask

  task automatic L(logic [31:0] v);
    op_q.push_back(2'b10);
    lit_q.push_back(v);
  endtask

  task automatic st(logic [31:0] dest, logic [31:0] val);
    L(dest); L(val); L(32'h0); O(2'b11);
  endtask

  task automatic jmp(logic [31:0] tgt);
    L(ONES); L(tgt); L(ONES); O(2'b11);
  endtask

  // unused slots are padded with SHR (01)
  task automatic flush();
    logic [31:0] w = 32'h5555_5555;
    foreach (op_q[i]) w[2*i +: 2] = op_q[i];
    mem[wp] = w;
    wp++;
    foreach (lit_q[i]) begin
      mem[wp] = lit_q[i];
      wp++;
    end
    op_q.delete();
    lit_q.delete();
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = sent(i);
    wp = HALT;
    jmp(HALT);
    flush();
    wp = 0;
  endtask

  task automatic go();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (RUN) @(negedge clk);
  endtask

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b, v, w;
    int k;
    void'($urandom(32'd2024));

    // R1 reset state
    begin_test();
    @(negedge clk);
    chk("R1 we in reset", {31'b0, mem_we}, 32'h0);
    chk("R1 addr in reset", mem_addr, 32'h0);
    st(32'd99, 32'h1234_5678); jmp(HALT); flush();
    go();
    chk("R1 first word runs", mem[99], 32'h1234_5678);

    // R2 slot order: later store to same address wins
    begin_test();
    st(32'd100, 32'd1); st(32'd100, 32'd2); jmp(HALT); flush();
    go();
    chk("R2 slot order", mem[100], 32'd2);

    // R3 NAND, random operands
    for (int i = 0; i < 8; i++) begin
      a = $urandom(); b = $urandom();
      if (i == 0) begin a = ONES; b = ONES; end
      if (i == 1) begin a = 32'h0; b = ONES; end
      begin_test();
      L(32'd101); L(a); L(b); O(2'b00); L(32'h0); O(2'b11); jmp(HALT); flush();
      go();
      chk("R3 nand", mem[101], f_nand(a, b));
    end

    // R4 SHR, bit 31 forced high
    for (int i = 0; i < 6; i++) begin
      a = $urandom() | 32'h8000_0000;
      k = 1 + (i % 2);
      begin_test();
      L(32'd102); L(a); O(2'b01);
      if (k == 2) O(2'b01);
      L(32'h0); O(2'b11); jmp(HALT); flush();
      go();
      chk("R4 shr", mem[102], f_shr(a, k));
    end

    // R6 plain store, random address and data
    for (int i = 0; i < 4; i++) begin
      v = $urandom();
      k = 120 + ($urandom() % 8);
      begin_test();
      st(32'(k), v); jmp(HALT); flush();
      go();
      chk("R6 store", mem[k], v);
    end

    // R5 literals consumed in order, next word after last literal
    begin_test();
    v = $urandom(); w = $urandom();
    st(32'd110, v); flush();
    st(32'd111, w); jmp(HALT); flush();
    go();
    chk("R5 first word", mem[110], v);
    chk("R5 next word at pc+4", mem[111], w);

    // R7 taken jump abandons remaining slots
    begin_test();
    v = $urandom();
    jmp(32'd20); st(32'd112, 32'hDEAD_BEEF); flush();
    wp = 20;
    st(32'd113, v); jmp(HALT); flush();
    go();
    chk("R7 skipped slots", mem[112], sent(112));
    chk("R7 target runs", mem[113], v);

    // R8 odd flag: no write, no jump, three dropped
    begin_test();
    v = $urandom(); w = $urandom();
    L(32'd114); L(v); L(32'd115); L(w); L(32'd5); O(2'b11);
    L(32'h0); O(2'b11); jmp(HALT); flush();
    go();
    chk("R8 odd flag no write", mem[115], sent(115));
    chk("R8 odd flag drops three", mem[114], v);

    // R8 all-ones flag, address not the PC
    begin_test();
    v = $urandom();
    L(32'd117); L(v); L(32'd116); L(32'd20); L(ONES); O(2'b11);
    L(32'h0); O(2'b11); jmp(HALT); flush();
    wp = 20;
    st(32'd118, 32'h0BAD_0BAD); jmp(HALT); flush();
    go();
    chk("R8 ones flag no write", mem[116], sent(116));
    chk("R8 ones flag no jump", mem[118], sent(118));
    chk("R8 ones flag drops three", mem[117], v);

    // R9 eighteen values held without loss
    begin_test();
    v = $urandom();
    L(32'd119); L(v);
    for (int i = 0; i < 14; i++) L(32'd5);
    flush();
    L(32'd5); L(32'd5); O(2'b00);
    for (int i = 0; i < 5; i++) O(2'b11);
    L(32'h0); O(2'b11); jmp(HALT); flush();
    go();
    chk("R9 depth 18", mem[119], v);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule